// File: doc/BRIEF.md
# Two-Way Tag-Only Cache Performance Model

This block models the presence of lines in a small two-way set-associative data cache. It keeps no data. A trace of memory references drives it. Each reference carries an operation code and a 32-bit byte address. For each reference the block looks up the tag state, decides whether the access hits or misses, and updates the valid, dirty and least-recently-used state. On a miss it allocates the line, including on writes.

One cycle after each read or write is accepted, the block pulses a result with hit, miss and dirty-eviction flags. At the same time it updates running counters: references, total hits, read hits, write hits, dirty write-backs and modelled access cycles. Average access time is the cycle counter divided by the reference counter. A reference with operation code 0 and address 0 ends the trace. After it the block raises a sticky done flag and accepts no more references.

Top module: `tag_cache2w`

## Requirements
- R1: After reset all counters read zero, `ref_ready` is high, `done` is low and every line is invalid, so the first access to any address misses.
- R2: The address splits into a 3-bit byte offset (bits 2:0), a 3-bit set index (bits 5:3) and a 26-bit tag (bits 31:6). All 26 tag bits are compared, and two addresses that differ only in the offset hit the same line.
- R3: Operation code 1 is a read and code 2 is a write. A reference is accepted only in a cycle where `ref_valid` and `ref_ready` are both high.
- R4: A reference with code 0 and address 0 sets `done`. From then on `done` stays high and `ref_ready` stays low until reset. The marker itself gives no result and changes no counter.
- R5: Code 3, and code 0 with a nonzero address, are consumed with no result, no counter change and no change to cache state.
- R6: Each accepted read or write yields exactly one `res_valid` pulse one cycle after acceptance. On that pulse exactly one of `res_hit` and `res_miss` is high.
- R7: Every miss allocates the line. A write miss leaves the line dirty and a read miss leaves it clean. A write hit makes the line dirty.
- R8: On a miss, an invalid way is filled before the LRU state is consulted, with way 0 taken before way 1.
- R9: When both ways are valid, a miss replaces the least recently used way. Any hit or fill makes the touched way the most recent.
- R10: Evicting a dirty line raises `res_wb` together with `res_miss` and adds one to `cnt_wb`. Evicting a clean line or filling an invalid way does neither.
- R11: `cnt_cycles` grows by 1 for each hit and by 50 for each miss.
- R12: `cnt_refs` counts accepted reads and writes, and `cnt_hits` counts their hits. `cnt_rd_hits` and `cnt_wr_hits` split the hits by operation, and the two always sum to `cnt_hits`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_valid | input | 1 | Reference offered |
| ref_ready | output | 1 | Block can accept a reference |
| ref_op | input | 2 | Operation code: 1 read, 2 write, 0 with address 0 ends the trace |
| ref_addr | input | 32 | Byte address |
| res_valid | output | 1 | Result strobe, one cycle after acceptance |
| res_hit | output | 1 | Access hit |
| res_miss | output | 1 | Access missed |
| res_wb | output | 1 | Miss evicted a dirty line |
| done | output | 1 | End-of-trace marker seen |
| cnt_refs | output | 32 | Accepted reads and writes |
| cnt_hits | output | 32 | Total hits |
| cnt_rd_hits | output | 32 | Read hits |
| cnt_wr_hits | output | 32 | Write hits |
| cnt_wb | output | 32 | Dirty write-backs |
| cnt_cycles | output | 32 | Modelled access cycles |

## Verification
The bench builds the block with its defaults: 32-bit addresses, 8-byte lines, 8 sets and 1 and 50 cycles for a hit and a miss. With only eight sets, a handful of addresses 64 bytes apart crowd one set, so the trace reaches LRU eviction, dirty and clean victims, and invalid-way fills within a few references. The full 26-bit tag compare is checked with two addresses that differ only in bit 31.

// File: rtl/tag_cache2w.sv
module tag_cache2w #(
  parameter int ADDR_W      = 32,
  parameter int LINE_BYTES  = 8,
  parameter int NUM_SETS    = 8,
  parameter int HIT_CYCLES  = 1,
  parameter int MISS_CYCLES = 50,
  parameter int CNT_W       = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_valid,
  output logic              ref_ready,
  input  logic [1:0]        ref_op,
  input  logic [ADDR_W-1:0] ref_addr,
  output logic              res_valid,
  output logic              res_hit,
  output logic              res_miss,
  output logic              res_wb,
  output logic              done,
  output logic [CNT_W-1:0]  cnt_refs,
  output logic [CNT_W-1:0]  cnt_hits,
  output logic [CNT_W-1:0]  cnt_rd_hits,
  output logic [CNT_W-1:0]  cnt_wr_hits,
  output logic [CNT_W-1:0]  cnt_wb,
  output logic [CNT_W-1:0]  cnt_cycles
);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int IDX_W = $clog2(NUM_SETS);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

  logic [NUM_SETS-1:0] vld [2];
  logic [NUM_SETS-1:0] dty [2];
  logic [NUM_SETS-1:0] lru;
  logic [TAG_W-1:0]    tags [2][NUM_SETS];

  logic             fire, is_rd, is_wr, is_end, is_acc;
  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;
  logic             hit0, hit1, hit, victim, way, wb_need;

  assign ref_ready = !done;
  assign fire      = ref_valid && ref_ready;
  assign is_rd     = ref_op == 2'd1;
  assign is_wr     = ref_op == 2'd2;
  assign is_end    = ref_op == 2'd0 && ref_addr == '0;
  assign is_acc    = fire && (is_rd || is_wr);
  assign idx       = ref_addr[OFF_W +: IDX_W];
  assign tag       = ref_addr[ADDR_W-1 -: TAG_W];

  assign hit0    = vld[0][idx] && tags[0][idx] == tag;
  assign hit1    = vld[1][idx] && tags[1][idx] == tag;
  assign hit     = hit0 || hit1;
  assign victim  = !vld[0][idx] ? 1'b0 : (!vld[1][idx] ? 1'b1 : lru[idx]);
  assign way     = hit ? hit1 : victim;
  assign wb_need = !hit && vld[victim][idx] && dty[victim][idx];

  always_ff @(posedge clk) begin
    if (is_acc && !hit) tags[victim][idx] <= tag;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld[0] <= '0; vld[1] <= '0;
      dty[0] <= '0; dty[1] <= '0;
      lru <= '0;
      done <= 1'b0;
      res_valid <= 1'b0; res_hit <= 1'b0; res_miss <= 1'b0; res_wb <= 1'b0;
      cnt_refs <= '0; cnt_hits <= '0; cnt_rd_hits <= '0;
      cnt_wr_hits <= '0; cnt_wb <= '0; cnt_cycles <= '0;
    end else begin
      res_valid <= is_acc;
      res_hit   <= is_acc && hit;
      res_miss  <= is_acc && !hit;
      res_wb    <= is_acc && wb_need;
      if (fire && is_end) done <= 1'b1;
      if (is_acc) begin
        lru[idx]      <= ~way;
        vld[way][idx] <= 1'b1;
        dty[way][idx] <= is_wr || (hit && dty[way][idx]);
        cnt_refs      <= cnt_refs + 1'b1;
        cnt_cycles    <= cnt_cycles + CNT_W'(hit ? HIT_CYCLES : MISS_CYCLES);
        if (hit) begin
          cnt_hits <= cnt_hits + 1'b1;
          if (is_rd) cnt_rd_hits <= cnt_rd_hits + 1'b1;
          else       cnt_wr_hits <= cnt_wr_hits + 1'b1;
        end
        if (wb_need) cnt_wb <= cnt_wb + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tag_cache2w_chk.sv
module tag_cache2w_chk #(
  parameter int CNT_W       = 32,
  parameter int HIT_CYCLES  = 1,
  parameter int MISS_CYCLES = 50
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ref_valid,
  input logic             ref_ready,
  input logic [1:0]       ref_op,
  input logic             res_valid,
  input logic             res_hit,
  input logic             res_miss,
  input logic             res_wb,
  input logic             done,
  input logic [CNT_W-1:0] cnt_refs,
  input logic [CNT_W-1:0] cnt_hits,
  input logic [CNT_W-1:0] cnt_rd_hits,
  input logic [CNT_W-1:0] cnt_wr_hits,
  input logic [CNT_W-1:0] cnt_wb,
  input logic [CNT_W-1:0] cnt_cycles
);
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_hit != res_miss)); // R6
  AST_RESULT_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(ref_valid && ref_ready && (ref_op == 2'd1 || ref_op == 2'd2))); // R6
  AST_WB_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    res_wb |-> res_valid && res_miss); // R10
  AST_WB_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    res_wb |-> cnt_wb == $past(cnt_wb) + 1'b1); // R10
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done); // R4
  AST_DONE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !ref_ready); // R4
  AST_HIT_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
    res_hit |-> cnt_cycles == $past(cnt_cycles) + CNT_W'(HIT_CYCLES)); // R11
  AST_MISS_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
    res_miss |-> cnt_cycles == $past(cnt_cycles) + CNT_W'(MISS_CYCLES)); // R11
  AST_REF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> $stable(cnt_refs)); // R12
  AST_HIT_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_hits == cnt_rd_hits + cnt_wr_hits); // R12
endmodule

bind tag_cache2w tag_cache2w_chk #(
  .CNT_W(CNT_W), .HIT_CYCLES(HIT_CYCLES), .MISS_CYCLES(MISS_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_ready(ref_ready),
  .ref_op(ref_op), .res_valid(res_valid), .res_hit(res_hit),
  .res_miss(res_miss), .res_wb(res_wb), .done(done), .cnt_refs(cnt_refs),
  .cnt_hits(cnt_hits), .cnt_rd_hits(cnt_rd_hits), .cnt_wr_hits(cnt_wr_hits),
  .cnt_wb(cnt_wb), .cnt_cycles(cnt_cycles)
);

// File: tb/tag_cache2w_bench.sv
module tag_cache2w_bench;
  localparam int CLK_P = 10;
  localparam int NV = 20;

  logic        clk = 1'b0, rst_n = 1'b0, ref_valid = 1'b0;
  logic [1:0]  ref_op = '0;
  logic [31:0] ref_addr = '0;
  logic        ref_ready, res_valid, res_hit, res_miss, res_wb, done;
  logic [31:0] cnt_refs, cnt_hits, cnt_rd_hits, cnt_wr_hits, cnt_wb, cnt_cycles;
  int checks = 0, fails = 0;

  always #(CLK_P/2) clk = ~clk;

  tag_cache2w u_tag_cache2w (
    .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_ready(ref_ready),
    .ref_op(ref_op), .ref_addr(ref_addr), .res_valid(res_valid),
    .res_hit(res_hit), .res_miss(res_miss), .res_wb(res_wb), .done(done),
    .cnt_refs(cnt_refs), .cnt_hits(cnt_hits), .cnt_rd_hits(cnt_rd_hits),
    .cnt_wr_hits(cnt_wr_hits), .cnt_wb(cnt_wb), .cnt_cycles(cnt_cycles)
  );

  // {op, addr, expect hit, expect write-back}; sets are 64 bytes apart per tag
  localparam logic [35:0] VEC [NV] = '{
    {2'd1, 32'h0000_0000, 1'b0, 1'b0}, // R1 R8 cold miss into way 0
    {2'd1, 32'h0000_0004, 1'b1, 1'b0}, // R2 same line, other offset
    {2'd2, 32'h0000_0040, 1'b0, 1'b0}, // R8 way 1 still invalid
    {2'd1, 32'h0000_0080, 1'b0, 1'b0}, // R9 evict LRU way 0, clean
    {2'd1, 32'h0000_0040, 1'b1, 1'b0}, // R9 refresh way 1
    {2'd1, 32'h0000_00C0, 1'b0, 1'b0}, // R9 evict way 0 clean
    {2'd1, 32'h0000_0100, 1'b0, 1'b1}, // R10 evict dirty way 1 (write miss)
    {2'd2, 32'h0000_00C0, 1'b1, 1'b0}, // R7 write hit dirties line
    {2'd1, 32'h0000_0140, 1'b0, 1'b0}, // R9 evict way 1 clean
    {2'd1, 32'h0000_0180, 1'b0, 1'b1}, // R10 evict write-hit dirty line
    {2'd2, 32'h0000_0008, 1'b0, 1'b0}, // R7 write miss in set 1
    {2'd2, 32'h0000_000C, 1'b1, 1'b0}, // R3 write hit
    {2'd1, 32'h0000_0048, 1'b0, 1'b0}, // R8 set 1 way 1
    {2'd1, 32'h0000_0088, 1'b0, 1'b1}, // R10 dirty from write-allocate
    {2'd1, 32'h0000_01FF, 1'b0, 1'b0}, // R2 set 7
    {2'd1, 32'h0000_01F8, 1'b1, 1'b0}, // R2 offset 0 same line
    {2'd1, 32'h0000_00C0, 1'b0, 1'b0}, // R9 evicted earlier, misses
    {2'd1, 32'hFFFF_FFC0, 1'b0, 1'b0}, // R2 max tag
    {2'd1, 32'h7FFF_FFC0, 1'b0, 1'b0}, // R2 differs only in bit 31
    {2'd1, 32'hFFFF_FFC4, 1'b1, 1'b0}  // R9 way 0 kept
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] op, input logic [31:0] addr);
    @(negedge clk);
    ref_valid = 1'b1; ref_op = op; ref_addr = addr;
    @(negedge clk);
    ref_valid = 1'b0;
  endtask

  task automatic counters(input string req, input int r, input int h, input int rh,
                          input int wh, input int wb, input int cy);
    chk({req, " refs"}, cnt_refs, r);
    chk({req, " hits"}, cnt_hits, h);
    chk({req, " rd_hits"}, cnt_rd_hits, rh);
    chk({req, " wr_hits"}, cnt_wr_hits, wh);
    chk({req, " wb"}, cnt_wb, wb);
    chk({req, " cycles"}, cnt_cycles, cy);
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int eh = 0, erh = 0, ewh = 0, ewb = 0, ecy = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    counters("R1 reset", 0, 0, 0, 0, 0, 0);
    chk("R1 ready", ref_ready, 1); chk("R1 done", done, 0);
    chk("R6 idle", res_valid, 0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][35:34], VEC[i][33:2]);
      chk($sformatf("R6 valid #%0d", i), res_valid, 1);
      chk($sformatf("R6 hit #%0d", i), res_hit, VEC[i][1]);
      chk($sformatf("R6 miss #%0d", i), res_miss, !VEC[i][1]);
      chk($sformatf("R10 wb #%0d", i), res_wb, VEC[i][0]);
      if (VEC[i][1]) begin
        eh++; ecy += 1;
        if (VEC[i][35:34] == 2'd1) erh++; else ewh++;
      end else ecy += 50;
      if (VEC[i][0]) ewb++;
      chk($sformatf("R11 cycles #%0d", i), cnt_cycles, ecy);
      @(negedge clk);
      chk($sformatf("R6 single pulse #%0d", i), res_valid, 0);
    end
    counters("R12 totals", NV, eh, erh, ewh, ewb, ecy);

    // R5: unused codes are consumed and change nothing
    drive(2'd3, 32'h0000_0000);
    chk("R5 op3 no result", res_valid, 0);
    drive(2'd0, 32'h0000_0040);
    chk("R5 op0 addr nonzero no result", res_valid, 0);
    chk("R5 not done", done, 0);
    counters("R5", NV, eh, erh, ewh, ewb, ecy);
    drive(2'd1, 32'hFFFF_FFC0);
    chk("R5 state kept hit", res_hit, 1);
    eh++; erh++; ecy += 1;

    // R3: valid held low accepts nothing
    @(negedge clk); ref_op = 2'd1; ref_addr = 32'h0;
    @(negedge clk);
    chk("R3 no valid no result", res_valid, 0);

    // R4: end marker
    drive(2'd0, 32'h0);
    chk("R4 done", done, 1); chk("R4 ready low", ref_ready, 0);
    chk("R4 marker no result", res_valid, 0);
    drive(2'd1, 32'h0000_0000);
    chk("R4 blocked no result", res_valid, 0);
    counters("R4", NV + 1, eh, erh, ewh, ewb, ecy);
    chk("R4 sticky", done, 1);

    // R1 R8: reset invalidates; both ways filled from invalid before LRU
    rst_n = 1'b0; @(negedge clk); @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 done cleared", done, 0);
    counters("R1 re-reset", 0, 0, 0, 0, 0, 0);
    drive(2'd1, 32'hFFFF_FFC4);
    chk("R1 invalidated miss", res_miss, 1);
    drive(2'd1, 32'h0000_0010);
    chk("R8 fill a", res_miss, 1);
    drive(2'd1, 32'h0000_0050);
    chk("R8 fill b", res_miss, 1);
    drive(2'd1, 32'h0000_0010);
    chk("R8 a kept", res_hit, 1);
    drive(2'd1, 32'h0000_0050);
    chk("R8 b kept", res_hit, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule